// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps wall-clock time for a chip. It counts seconds, minutes and hours in packed BCD and whole days in binary. It runs from a periodic base tick enable: a built-in phase counter turns a fixed number of base ticks into one second step. Each second step is an update cycle. In that cycle the whole time-of-day and day count advance together, with every carry resolved at once.

A host reaches the time fields, the alarm fields and one control/status byte through a byte-wide request channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The block lowers `req_ready` for the single update cycle of each second step, so the host is stalled and no access can collide with the update. A read returns its byte on `rsp_data` with `rsp_valid` high in the cycle after acceptance. No ready signal exists on the response side, so the host must take the response in that cycle. A write returns no response.

The alarm compares minute, hour and day against the count. Each of the three fields has its own enable. On a match the alarm sets a sticky flag, which software clears by writing one to it, and drives an interrupt line gated by an enable.

Top module: `cal_keeper`

## Requirements
- R1: Seconds count in packed BCD from 0x00 to 0x59. The low digit rolls from 9 to 0 and carries into the high digit. Past 0x59 the field returns to 0x00 and advances minutes.
- R2: Minutes count 0x00..0x59 in BCD and carry into hours. Hours count 0x00..0x23 in BCD. Past 0x23 hours return to 0x00 and advance the day count.
- R3: The day count is binary, 0 to 0x7FFF, and wraps from 0x7FFF to 0. Address 3 holds bits 7:0. Address 4 holds bits 14:8 in its bits 6:0; its bit 7 reads 0 and ignores writes.
- R4: Control bit 7 is a read-only busy bit. It is high for exactly the one update cycle of each second step, and `req_ready` is low in that cycle. Writes to bit 7 have no effect, and it reads 0 at any other time.
- R5: Control bit 0 is the run enable. While it is 0, base ticks are ignored and no field counts.
- R6: The alarm compares minute (address 5, BCD), hour (address 6, BCD) and a 16-bit day (address 7 low byte, address 8 high byte). Control bits 3, 4 and 5 enable the minute, hour and day compares. Seconds are never compared. The alarm fires on an update that makes every enabled field equal the count when they were not all equal before. With no compare enabled, the alarm never fires.
- R7: Control bit 2 is the alarm flag. It stays set until the host writes a 1 to bit 2. Writing 0 to bit 2 leaves it unchanged. If a set and a clear occur in the same cycle, the set wins.
- R8: `alarm_irq` equals the alarm flag ANDed with control bit 1, the interrupt enable.
- R9: Seconds advance once per `TICKS_PER_SEC` base ticks. Writing the seconds field restarts that phase count; writing any other field does not. Time fields change only on an update or a host write.
- R10: After reset, every register reads 0x00 and `alarm_irq` is low.
- R11: Register map: 0 seconds, 1 minutes, 2 hours, 3 day low, 4 day high, 5 alarm minute, 6 alarm hour, 7 alarm day low, 8 alarm day high, 9 control. Other addresses read 0x00 and ignore writes. Read data appears one cycle after acceptance, and writes return no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle base tick enable; `TICKS_PER_SEC` of these make one second |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request can be accepted (low during an update cycle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_data | output | 8 | Read data |
| alarm_irq | output | 1 | Alarm interrupt (flag AND interrupt enable) |

## Verification
The counter is tried with three starting points. The first is a digit that rolls inside a field (x9). The second is a chain where seconds, minutes and hours all roll in one update, which shows whether the carries ripple in a single cycle. The third is the day count at its largest value, which separates the wrap to 0 from an overflow into the high byte. The phase counter is tried with a seconds write in the middle of a second and with a minutes write in the middle of a second, which separates the phase restart from an accidental restart. The alarm is tried with all enables on, with a mismatching field enabled and then disabled, with the interrupt enable off, with no compare enabled, and with a further update that keeps the match. These cases tell field masking, interrupt gating, edge-only firing and the write-one-to-clear rule apart.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // Register addresses on the host channel
  typedef enum logic [3:0] {
    A_SEC   = 4'd0,
    A_MIN   = 4'd1,
    A_HOUR  = 4'd2,
    A_DAYL  = 4'd3,
    A_DAYH  = 4'd4,
    A_AMIN  = 4'd5,
    A_AHOUR = 4'd6,
    A_ADAYL = 4'd7,
    A_ADAYH = 4'd8,
    A_CTRL  = 4'd9
  } reg_addr_e;

  // Control byte bit positions (host software decodes these)
  localparam int CB_RUN  = 0;
  localparam int CB_IE   = 1;
  localparam int CB_FLAG = 2;
  localparam int CB_MEN  = 3;
  localparam int CB_HEN  = 4;
  localparam int CB_DEN  = 5;
  localparam int CB_BUSY = 7;

  // One packed-BCD step: returns {wrapped, next value}
  function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] top);
    if (v >= top)          return {1'b1, 8'h00};
    else if (v[3:0] >= 4'd9) return {1'b0, v[7:4] + 4'd1, 4'h0};
    else                   return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/cal_prescale.sv
module cal_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic base_tick,
  input  logic phase_clr,
  output logic sec_pulse
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= 1'b0;
      if (phase_clr) begin
        phase <= '0;
      end else if (run && base_tick) begin
        if (phase == LAST) begin
          phase     <= '0;
          sec_pulse <= 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wr_sec,
  input  logic             wr_min,
  input  logic             wr_hour,
  input  logic             wr_dayl,
  input  logic             wr_dayh,
  input  logic [7:0]       wdata,
  output logic [7:0]       sec,
  output logic [7:0]       min,
  output logic [7:0]       hour,
  output logic [DAY_W-1:0] day,
  output logic [7:0]       nxt_min,
  output logic [7:0]       nxt_hour,
  output logic [DAY_W-1:0] nxt_day
);
  import cal_pkg::*;

  localparam logic [DAY_W-1:0] DAY_MAX = {DAY_W{1'b1}};

  logic [8:0]  s_st, m_st, h_st;
  logic [15:0] day_ext;
  logic        day_roll;

  always_comb begin
    s_st     = bcd_step(sec,  8'h59);
    m_st     = bcd_step(min,  8'h59);
    h_st     = bcd_step(hour, 8'h23);
    nxt_min  = s_st[8] ? m_st[7:0] : min;
    nxt_hour = (s_st[8] && m_st[8]) ? h_st[7:0] : hour;
    day_roll = s_st[8] && m_st[8] && h_st[8];
    if (!day_roll)            nxt_day = day;
    else if (day == DAY_MAX)  nxt_day = '0;
    else                      nxt_day = day + 1'b1;
    day_ext  = 16'(day);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= '0;
      min  <= '0;
      hour <= '0;
      day  <= '0;
    end else if (step) begin
      sec  <= s_st[7:0];
      min  <= nxt_min;
      hour <= nxt_hour;
      day  <= nxt_day;
    end else begin
      if (wr_sec)  sec  <= wdata;
      if (wr_min)  min  <= wdata;
      if (wr_hour) hour <= wdata;
      if (wr_dayl) day  <= DAY_W'({day_ext[15:8], wdata});
      if (wr_dayh) day  <= DAY_W'({wdata, day_ext[7:0]});
    end
  end
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic             men,
  input  logic             hen,
  input  logic             den,
  input  logic [7:0]       amin,
  input  logic [7:0]       ahour,
  input  logic [15:0]      aday,
  input  logic [7:0]       cur_min,
  input  logic [7:0]       cur_hour,
  input  logic [DAY_W-1:0] cur_day,
  input  logic [7:0]       nxt_min,
  input  logic [7:0]       nxt_hour,
  input  logic [DAY_W-1:0] nxt_day,
  output logic             flag
);
  logic any_en, hit_cur, hit_nxt;

  always_comb begin
    any_en  = men || hen || den;
    hit_cur = any_en && (!men || cur_min == amin) && (!hen || cur_hour == ahour)
                     && (!den || 16'(cur_day) == aday);
    hit_nxt = any_en && (!men || nxt_min == amin) && (!hen || nxt_hour == ahour)
                     && (!den || 16'(nxt_day) == aday);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          flag <= 1'b0;
    else if (step && hit_nxt && !hit_cur) flag <= 1'b1;
    else if (clr)                        flag <= 1'b0;
  end
endmodule

// File: rtl/cal_keeper.sv
module cal_keeper #(
  parameter int TICKS_PER_SEC = 4,
  parameter int DAY_W         = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [3:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       alarm_irq
);
  import cal_pkg::*;

  logic             busy, acc, wr_acc, step;
  logic             run_q, ie_q, men_q, hen_q, den_q, flag_q;
  logic [7:0]       amin_q, ahour_q;
  logic [15:0]      aday_q;
  logic [7:0]       sec_q, min_q, hour_q;
  logic [DAY_W-1:0] day_q;
  logic [7:0]       nxt_min, nxt_hour;
  logic [DAY_W-1:0] nxt_day;
  logic [15:0]      day_ext;
  logic [7:0]       rd_byte;
  logic             wsel_sec, wsel_min, wsel_hour, wsel_dayl, wsel_dayh, wsel_ctrl;
  logic             flag_clr;

  assign req_ready = !busy;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign step      = busy && run_q;
  assign day_ext   = 16'(day_q);

  assign wsel_sec  = wr_acc && (req_addr == A_SEC);
  assign wsel_min  = wr_acc && (req_addr == A_MIN);
  assign wsel_hour = wr_acc && (req_addr == A_HOUR);
  assign wsel_dayl = wr_acc && (req_addr == A_DAYL);
  assign wsel_dayh = wr_acc && (req_addr == A_DAYH);
  assign wsel_ctrl = wr_acc && (req_addr == A_CTRL);
  assign flag_clr  = wsel_ctrl && req_wdata[CB_FLAG];

  cal_prescale #(.DIV(TICKS_PER_SEC)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .base_tick (base_tick),
    .phase_clr (wsel_sec),
    .sec_pulse (busy)
  );

  cal_time_core #(.DAY_W(DAY_W)) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .wr_sec   (wsel_sec),
    .wr_min   (wsel_min),
    .wr_hour  (wsel_hour),
    .wr_dayl  (wsel_dayl),
    .wr_dayh  (wsel_dayh),
    .wdata    (req_wdata),
    .sec      (sec_q),
    .min      (min_q),
    .hour     (hour_q),
    .day      (day_q),
    .nxt_min  (nxt_min),
    .nxt_hour (nxt_hour),
    .nxt_day  (nxt_day)
  );

  cal_alarm #(.DAY_W(DAY_W)) u_alm (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .clr      (flag_clr),
    .men      (men_q),
    .hen      (hen_q),
    .den      (den_q),
    .amin     (amin_q),
    .ahour    (ahour_q),
    .aday     (aday_q),
    .cur_min  (min_q),
    .cur_hour (hour_q),
    .cur_day  (day_q),
    .nxt_min  (nxt_min),
    .nxt_hour (nxt_hour),
    .nxt_day  (nxt_day),
    .flag     (flag_q)
  );

  // Control and alarm registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ie_q    <= 1'b0;
      men_q   <= 1'b0;
      hen_q   <= 1'b0;
      den_q   <= 1'b0;
      amin_q  <= '0;
      ahour_q <= '0;
      aday_q  <= '0;
    end else if (wr_acc) begin
      case (req_addr)
        A_AMIN:  amin_q        <= req_wdata;
        A_AHOUR: ahour_q       <= req_wdata;
        A_ADAYL: aday_q[7:0]   <= req_wdata;
        A_ADAYH: aday_q[15:8]  <= req_wdata;
        A_CTRL: begin
          run_q <= req_wdata[CB_RUN];
          ie_q  <= req_wdata[CB_IE];
          men_q <= req_wdata[CB_MEN];
          hen_q <= req_wdata[CB_HEN];
          den_q <= req_wdata[CB_DEN];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    case (req_addr)
      A_SEC:   rd_byte = sec_q;
      A_MIN:   rd_byte = min_q;
      A_HOUR:  rd_byte = hour_q;
      A_DAYL:  rd_byte = day_ext[7:0];
      A_DAYH:  rd_byte = day_ext[15:8];
      A_AMIN:  rd_byte = amin_q;
      A_AHOUR: rd_byte = ahour_q;
      A_ADAYL: rd_byte = aday_q[7:0];
      A_ADAYH: rd_byte = aday_q[15:8];
      A_CTRL:  rd_byte = {busy, 1'b0, den_q, hen_q, men_q, flag_q, ie_q, run_q};
      default: rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc && !req_write;
      if (acc && !req_write) rsp_data <= rd_byte;
    end
  end

  assign alarm_irq = flag_q && ie_q;

endmodule

// File: rtl/cal_keeper_chk.sv
module cal_keeper_chk #(
  parameter int DAY_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             run,
  input logic             acc_wr,
  input logic [7:0]       sec,
  input logic [7:0]       min,
  input logic [7:0]       hour,
  input logic [DAY_W-1:0] day,
  input logic             flag
);
  localparam logic [DAY_W-1:0] DAY_MAX = {DAY_W{1'b1}};

  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && run && sec == 8'h59 |=> sec == 8'h00);

  p_hour_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && run && sec == 8'h59 && min == 8'h59 && hour == 8'h23 |=> hour == 8'h00 && min == 8'h00);

  p_day_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && run && sec == 8'h59 && min == 8'h59 && hour == 8'h23 && day == DAY_MAX |=> day == '0);

  p_busy_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_flag_on_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(busy));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !acc_wr |=> $stable(sec) && $stable(min) && $stable(hour) && $stable(day));

endmodule

bind cal_keeper cal_keeper_chk #(.DAY_W(DAY_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .run    (run_q),
  .acc_wr (wr_acc),
  .sec    (sec_q),
  .min    (min_q),
  .hour   (hour_q),
  .day    (day_q),
  .flag   (flag_q)
);

// File: tb/test_cal_keeper.sv
`timescale 1ns/1ps
module test_cal_keeper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       alarm_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  cal_keeper i_cal_keeper (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .alarm_irq(alarm_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as read responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected response actual=%02h expected=none", rsp_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rsp_data, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic base(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); base_tick = 1'b1;
      @(negedge clk); base_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic secs(input int n);
    base(4 * n);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(4'd0, 8'h00, "R10 sec after reset");
    rd(4'd9, 8'h00, "R10 ctrl after reset");
    rd(4'd4, 8'h00, "R10 day high after reset");
    @(negedge clk); check("R10 irq after reset", {7'b0, alarm_irq}, 8'h00);

    // R5 run off: ticks ignored
    base(8);
    rd(4'd0, 8'h00, "R5 no count while stopped");

    // R1 low digit carry; R3 day bytes
    wr(4'd0, 8'h09); wr(4'd1, 8'h19); wr(4'd2, 8'h05);
    wr(4'd3, 8'h34); wr(4'd4, 8'h12);
    @(negedge clk); check("R11 no response to write", {7'b0, rsp_valid}, 8'h00);
    wr(4'd9, 8'h01);
    secs(1);
    rd(4'd0, 8'h10, "R1 sec 09->10");
    rd(4'd3, 8'h34, "R3 day low held");
    rd(4'd4, 8'h12, "R3 day high held");

    // R1/R2 carry chain into hour digit
    wr(4'd0, 8'h58); wr(4'd1, 8'h59); wr(4'd2, 8'h09);
    secs(2);
    rd(4'd0, 8'h00, "R1 sec wrap");
    rd(4'd1, 8'h00, "R2 min wrap");
    rd(4'd2, 8'h10, "R2 hour 09->10");

    // R2 hour into day, R3 day wrap
    wr(4'd0, 8'h59); wr(4'd1, 8'h59); wr(4'd2, 8'h23);
    wr(4'd3, 8'hFE); wr(4'd4, 8'h7F);
    secs(1);
    rd(4'd2, 8'h00, "R2 hour wrap");
    rd(4'd3, 8'hFF, "R2 day increment low");
    rd(4'd4, 8'h7F, "R2 day increment high");
    wr(4'd0, 8'h59); wr(4'd1, 8'h59); wr(4'd2, 8'h23);
    secs(1);
    rd(4'd3, 8'h00, "R3 day wrap low");
    rd(4'd4, 8'h00, "R3 day wrap high");
    wr(4'd4, 8'hFF);
    rd(4'd4, 8'h7F, "R3 day high bit7 ignored");
    wr(4'd4, 8'h00);

    // R9 phase restart
    wr(4'd0, 8'h20);
    base(2);
    wr(4'd0, 8'h30);
    base(3);
    rd(4'd0, 8'h30, "R9 sec write restarts phase");
    base(1);
    rd(4'd0, 8'h31, "R9 second after full phase");
    base(2);
    wr(4'd1, 8'h40);
    base(2);
    rd(4'd0, 8'h32, "R9 min write keeps phase");

    // R4 busy cycle
    base(3);
    @(negedge clk); base_tick = 1'b1;
    @(negedge clk); base_tick = 1'b0;
    check("R4 ready low in update cycle", {7'b0, req_ready}, 8'h00);
    @(negedge clk);
    check("R4 ready back after update", {7'b0, req_ready}, 8'h01);
    rd(4'd9, 8'h01, "R4 busy reads 0 when idle");
    wr(4'd9, 8'h81);
    rd(4'd9, 8'h01, "R4 busy bit not writable");
    rd(4'd0, 8'h33, "R4 update applied");

    // R6/R7/R8 alarm minute+hour
    wr(4'd5, 8'h05); wr(4'd6, 8'h01); wr(4'd7, 8'h00); wr(4'd8, 8'h00);
    wr(4'd9, 8'h1B);
    wr(4'd2, 8'h01); wr(4'd1, 8'h04); wr(4'd0, 8'h59);
    secs(1);
    @(negedge clk); check("R8 irq on alarm", {7'b0, alarm_irq}, 8'h01);
    rd(4'd9, 8'h1F, "R6 flag set on match");
    wr(4'd9, 8'h1B);
    rd(4'd9, 8'h1F, "R7 writing 0 keeps flag");
    wr(4'd9, 8'h1F);
    rd(4'd9, 8'h1B, "R7 write one clears flag");
    @(negedge clk); check("R8 irq drops with flag", {7'b0, alarm_irq}, 8'h00);
    secs(1);
    rd(4'd9, 8'h1B, "R6 no refire while match holds");

    // R6 disabled field ignored
    wr(4'd6, 8'h07); wr(4'd9, 8'h0B);
    wr(4'd1, 8'h04); wr(4'd0, 8'h59);
    secs(1);
    rd(4'd9, 8'h0F, "R6 hour disabled, minute match fires");
    wr(4'd9, 8'h1F);
    wr(4'd1, 8'h04); wr(4'd0, 8'h59);
    secs(1);
    rd(4'd9, 8'h1B, "R6 enabled hour mismatch blocks");
    @(negedge clk); check("R8 irq low without flag", {7'b0, alarm_irq}, 8'h00);

    // R8 interrupt enable off
    wr(4'd6, 8'h01); wr(4'd9, 8'h09);
    wr(4'd1, 8'h04); wr(4'd0, 8'h59);
    secs(1);
    rd(4'd9, 8'h0D, "R8 flag set with ie off");
    @(negedge clk); check("R8 irq masked", {7'b0, alarm_irq}, 8'h00);

    // R6 no compare enabled never fires
    wr(4'd9, 8'h07);
    wr(4'd1, 8'h04); wr(4'd0, 8'h59);
    secs(1);
    rd(4'd9, 8'h03, "R6 no enables never fires");

    // R11 map
    rd(4'd15, 8'h00, "R11 unmapped reads zero");
    rd(4'd6, 8'h01, "R11 alarm hour readback");
    rd(4'd5, 8'h05, "R11 alarm minute readback");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11 missing responses actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule